// File: doc/BRIEF.md
# Segment-Terminated Rate-1/3 Convolutional Encoder

This block encodes a serial bit stream with a rate one-third convolutional code of constraint length nine. Every accepted information bit yields one registered three-bit code symbol. Each output bit is the parity of a parameterised generator polynomial applied to the window made of the incoming bit and the eight previous bits held in the state register.

The encoder does not run freely across the whole stream. After every `SEG_LEN` accepted bits it returns its state register to all zeros, so each segment starts from the same known trellis state. A downstream decoder can therefore begin each segment without carrying survivor history across the boundary. The symbol of the final bit of a segment is still emitted normally. It is flagged by a one-cycle boundary strobe, and the state is cleared before the next bit is taken.

Top module: `conv_seg_encoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` and `seg_end` are 0. Reset loads the all-zero state and starts a new segment.
- R2: Each cycle in which `in_valid` is 1 produces exactly one symbol, with `out_valid` high one clock later. `out_valid` is 0 in the cycle after any cycle in which `in_valid` is 0.
- R3: With window w = {in_bit, state[7:0]} (w[8] is the current bit, w[7] the previous one, w[0] the oldest), output bit `sym[k]` = XOR of (w AND Gk), with G0 = octal 557, G1 = octal 663 and G2 = octal 711. A 1 entering a zero state gives `sym` = 3'b111.
- R4: A cycle with `in_valid` at 0 changes neither the state nor the segment position.
- R5: After the `SEG_LEN`-th accepted bit of a segment (default 64), the state is all zeros before the next bit is encoded.
- R6: `seg_end` is 1 exactly in the cycle that carries the symbol of the last bit of a segment, and 0 in every other cycle.
- R7: A synchronous reset in the middle of a segment clears the state and restarts the segment count from the next accepted bit.
- R8: `sym` keeps its value in every cycle in which `out_valid` is 0, apart from the reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Information bit |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| sym | output | 3 | Code symbol; bit k comes from generator Gk |
| out_valid | output | 1 | `sym` holds a new symbol |
| seg_end | output | 1 | Strobe marking the symbol of the last bit of a segment |

## Verification
A single 1 after reset checks the generator taps on the newest bit. An all-ones run fills every state position, so it separates the three polynomials from one another. A pseudo-random stream with idle gaps covers arbitrary state contents and shows that gaps neither shift the state nor advance the segment count. The streams run over several segment boundaries, which exposes a clear that arrives one bit early or late, or a missing clear. A reset in mid-segment followed by a full segment shows whether the boundary grid restarts from that reset.

// File: rtl/conv_seg_pkg.sv
package conv_seg_pkg;

    localparam int CODE_OUTS = 3;
    localparam int DEF_K     = 9;

    localparam logic [DEF_K-1:0] DEF_G0 = 9'o557;
    localparam logic [DEF_K-1:0] DEF_G1 = 9'o663;
    localparam logic [DEF_K-1:0] DEF_G2 = 9'o711;

    typedef logic [CODE_OUTS-1:0] code_sym_t;

endpackage

// File: rtl/conv_seg_taps.sv
module conv_seg_taps
    import conv_seg_pkg::*;
#(
    parameter int K = DEF_K,
    parameter logic [CODE_OUTS-1:0][K-1:0] GENS = {DEF_G2, DEF_G1, DEF_G0}
) (
    input  logic          cur_bit,
    input  logic [K-2:0]  hist,
    output code_sym_t     code
);
    logic [K-1:0] window;

    assign window = {cur_bit, hist};

    for (genvar g = 0; g < CODE_OUTS; g++) begin : g_parity
        assign code[g] = ^(window & GENS[g]);
    end

endmodule

// File: rtl/conv_seg_counter.sv
module conv_seg_counter #(
    parameter int SEG_LEN = 64,
    localparam int CW = (SEG_LEN > 2) ? $clog2(SEG_LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic at_last
);
    typedef struct packed {
        logic [CW-1:0] pos;
    } cnt_t;

    localparam logic [CW-1:0] LAST_POS = CW'(SEG_LEN - 1);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q.pos == LAST_POS) cnt_d.pos = '0;
            else                       cnt_d.pos = cnt_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q.pos == LAST_POS);

endmodule

// File: rtl/conv_seg_encoder.sv
module conv_seg_encoder
    import conv_seg_pkg::*;
#(
    parameter int K       = DEF_K,
    parameter int SEG_LEN = 64,
    parameter logic [K-1:0] G0 = DEF_G0,
    parameter logic [K-1:0] G1 = DEF_G1,
    parameter logic [K-1:0] G2 = DEF_G2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_bit,
    input  logic       in_valid,
    output logic [2:0] sym,
    output logic       out_valid,
    output logic       seg_end
);
    localparam int MEM = K - 1;

    typedef struct packed {
        logic [MEM-1:0] state;
        code_sym_t      sym;
        logic           out_valid;
        logic           seg_end;
    } enc_t;

    enc_t      enc_d, enc_q;
    code_sym_t code_now;
    logic      last_bit;

    conv_seg_taps #(
        .K    (K),
        .GENS ({G2, G1, G0})
    ) u_taps (
        .cur_bit (in_bit),
        .hist    (enc_q.state),
        .code    (code_now)
    );

    conv_seg_counter #(
        .SEG_LEN (SEG_LEN)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (in_valid),
        .at_last (last_bit)
    );

    always_comb begin
        enc_d           = enc_q;
        enc_d.out_valid = in_valid;
        enc_d.seg_end   = in_valid && last_bit;
        if (in_valid) begin
            enc_d.sym = code_now;
            if (last_bit) enc_d.state = '0;
            else          enc_d.state = {in_bit, enc_q.state[MEM-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) enc_q <= '0;
        else     enc_q <= enc_d;
    end

    assign sym       = enc_q.sym;
    assign out_valid = enc_q.out_valid;
    assign seg_end   = enc_q.seg_end;

endmodule

// File: rtl/conv_seg_encoder_chk.sv
module conv_seg_encoder_chk #(
    parameter int SEG_LEN = 64,
    localparam int CW = (SEG_LEN > 2) ? $clog2(SEG_LEN) : 1
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] sym,
    input logic       out_valid,
    input logic       seg_end
);
    logic          prev_rst = 1'b0;
    logic          live_q   = 1'b0;
    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst) begin
            live_q <= 1'b0;
            seen_q <= '0;
        end else begin
            live_q <= 1'b1;
            if (out_valid)
                seen_q <= (seen_q == CW'(SEG_LEN - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        prev_rst |-> (!out_valid && !seg_end));                        // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (out_valid == $past(in_valid)));                     // R2

    AST_END_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        seg_end |-> out_valid);                                         // R6

    AST_END_ON_GRID: assert property (@(posedge clk) disable iff (rst)
        seg_end == (out_valid && seen_q == CW'(SEG_LEN - 1)));          // R6

    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (live_q && !out_valid) |-> $stable(sym));                       // R8

endmodule

bind conv_seg_encoder conv_seg_encoder_chk #(.SEG_LEN(SEG_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sym       (sym),
    .out_valid (out_valid),
    .seg_end   (seg_end)
);

// File: tb/conv_seg_encoder_bench.sv
module conv_seg_encoder_bench;

    localparam int SEG = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_bit = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] sym;
    logic       out_valid;
    logic       seg_end;

    int checks = 0;
    int errors = 0;

    logic [3:0] exp_q[$];
    logic [7:0] ref_state = '0;
    int         ref_pos = 0;
    logic [2:0] last_sym = '0;
    bit         last_seen = 0;

    always #2 clk = ~clk;

    conv_seg_encoder #(.SEG_LEN(SEG)) u_conv_seg_encoder (
        .clk (clk), .rst (rst), .in_bit (in_bit), .in_valid (in_valid),
        .sym (sym), .out_valid (out_valid), .seg_end (seg_end)
    );

    function automatic logic [2:0] ref_code(input logic b, input logic [7:0] st);
        logic [8:0] gens [3];
        logic [8:0] w;
        logic [2:0] r;
        gens[0] = 9'o557; gens[1] = 9'o663; gens[2] = 9'o711;
        w = {b, st};
        for (int k = 0; k < 3; k++) begin
            r[k] = 1'b0;
            for (int i = 0; i < 9; i++) r[k] = r[k] ^ (w[i] & gens[k][i]);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic b);
        logic [2:0] c;
        logic       endf;
        @(negedge clk);
        c    = ref_code(b, ref_state);
        endf = (ref_pos == SEG - 1);
        exp_q.push_back({endf, c});
        if (endf) begin
            ref_state = '0;
            ref_pos   = 0;
        end else begin
            ref_state = {b, ref_state[7:1]};
            ref_pos++;
        end
        in_bit   = b;
        in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_bit   = ~in_bit;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        exp_q.delete();
        ref_state = '0;
        ref_pos   = 0;
        last_seen = 0;
        @(negedge clk);
        check(!out_valid && !seg_end, "R1 outputs during reset", {out_valid, seg_end}, 0);
        rst = 1'b0;
    endtask

    // monitor: compare each produced symbol against the queue
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2/R4 unexpected symbol", {seg_end, sym}, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check({seg_end, sym} == e, "R3/R5/R6/R7 symbol+end", {seg_end, sym}, e);
                end
                last_sym  = sym;
                last_seen = 1;
            end else begin
                check(!seg_end, "R6 strobe without symbol", seg_end, 0);
                if (last_seen)
                    check(sym == last_sym, "R8 sym hold", sym, last_sym);
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        @(negedge clk);
        check(!out_valid && !seg_end, "R1 first cycle after reset", {out_valid, seg_end}, 0);

        // R3: single 1 into zero state
        send(1'b1);
        idle(1);
        check(out_valid && sym == 3'b111, "R3 impulse symbol", {out_valid, sym}, 4'hF);
        idle(3);
        check(!out_valid, "R2 no symbol after idle", out_valid, 0);

        // all ones across segment boundaries
        do_reset();
        for (int i = 0; i < 2 * SEG + 5; i++) send(1'b1);
        idle(2);

        // pseudo-random with gaps (R4)
        lfsr = 16'hACE1;
        for (int i = 0; i < 3 * SEG; i++) begin
            send(lfsr[0]);
            if (lfsr[3]) idle(1 + int'(lfsr[5:4]));
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        idle(2);

        // alternating, then mid-segment reset (R7) and a full segment
        for (int i = 0; i < 20; i++) send(i[0]);
        do_reset();
        for (int i = 0; i < SEG + 3; i++) send(~i[1]);
        idle(3);

        check(exp_q.size() == 0, "R2 every bit produced a symbol", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule